// File: doc/BRIEF.md
# Shadowed Control Register Bank

This block holds a small set of byte-wide control registers addressed by a 3-bit index. Two of them, at index 1 and index 3, are shadowed. Each has a retained (nonvolatile) copy and a live (volatile) copy. Only the live copies drive device behaviour, and they are brought out as `live1` and `live3`. A persist-mode bit in register 0 chooses what a write to a shadowed register does. With the bit set, the write updates both copies. With the bit clear, it updates only the live copy, so the new value is lost at the next power cycle.

Several writes also recall retained values into the live copies. A write to one shadowed register reloads the other one's live copy from its retained copy. With persist mode off, a write to register 0 or register 5 reloads both live copies. Reads of the shadowed registers always return the retained copy. A write-enable latch in register 6 gates every other write, and an active-low write-protect input blocks every write except one to the latch. The power-up reset `rst_n` loads the live copies from the retained ones and clears the latch. The retained registers keep their contents through that reset.

Top module: `shadow_ctl_bank`

## Requirements
- R1: While `rst_n` is low, `live1` and `live3` load the retained values of registers 1 and 3, and the enable latch clears, so a read of index 6 returns 0. At first power-up the retained values are NV1_INIT (5Ah) and NV3_INIT (C3h).
- R2: When persist bit 7 of register 0 is 1, an accepted write to index 1 or 3 sets both the live copy and the retained copy. The read-back shows the new value, and a later reset keeps it.
- R3: When persist bit 7 is 0, an accepted write to index 1 or 3 updates only the live output. The read-back and the value restored by reset stay at the old retained value.
- R4: An accepted write to index 1 reloads `live3` from the retained register 3. An accepted write to index 3 reloads `live1` from the retained register 1.
- R5: When persist bit 7 is 0, an accepted write to index 0 or 5 reloads both live copies from their retained copies.
- R6: The persist bit that decides R2, R3 and R5 is its value before the write. A write to index 0 that sets the bit still performs the R5 reload.
- R7: While `wp_n` is low, a write to any index other than 6 changes nothing and triggers no reload. A write to index 6 still updates the enable latch.
- R8: The enable latch is bit 1 of register 6 and is set or cleared by any write to index 6. While it is 0, writes to indices 0 to 5 are ignored.
- R9: Indices 2 and 4 read back what was written to them, index 5 reads its stored byte, index 6 reads the latch in bit 1 with all other bits 0, and index 7 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset (synchronous) |
| wp_n | input | 1 | Active-low write protect |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Register index written |
| wr_data | input | 8 | Byte written |
| rd_addr | input | 3 | Register index read |
| rd_data | output | 8 | Read data (combinational) |
| live1 | output | 8 | Live copy of register 1 |
| live3 | output | 8 | Live copy of register 3 |

## Verification
The bench deliberately drives the live and retained copies of each shadowed register to different values, so that any recall shows up on the outputs. A design that skipped the cross recall, or reloaded the wrong register, would leave a stale live value after a write to the other shadowed register. A design that reads the live copy would return the unsaved byte on read-back. A design that decides the bulk recall with the new persist bit would keep the stale live byte when persist mode is switched on. A reset in the middle of the test shows whether retained values survive a power cycle. Writes under write protect and with the latch cleared show whether a design still stores data or still triggers a recall when it should not.

// File: rtl/shadow_ctl_bank.sv
module shadow_ctl_bank #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int MODE_BIT = 7,
  parameter int WEL_BIT = 1,
  parameter logic [DW-1:0] NV1_INIT = 8'h5A,
  parameter logic [DW-1:0] NV3_INIT = 8'hC3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] live1,
  output logic [DW-1:0] live3
);
  localparam logic [AW-1:0] A_C0 = AW'(0);
  localparam logic [AW-1:0] A_C1 = AW'(1);
  localparam logic [AW-1:0] A_C2 = AW'(2);
  localparam logic [AW-1:0] A_C3 = AW'(3);
  localparam logic [AW-1:0] A_C4 = AW'(4);
  localparam logic [AW-1:0] A_C5 = AW'(5);
  localparam logic [AW-1:0] A_C6 = AW'(6);

  // retained storage: untouched by rst_n
  logic [DW-1:0] nv1_q = NV1_INIT;
  logic [DW-1:0] nv3_q = NV3_INIT;
  logic [DW-1:0] c0_q = '0;
  logic [DW-1:0] c2_q = '0;
  logic [DW-1:0] c4_q = '0;
  logic [DW-1:0] c5_q = '0;

  logic [DW-1:0] live1_q, live3_q;
  logic          wel_q;

  logic mode, wr_ok, hit0, hit1, hit2, hit3, hit4, hit5, hit6, recall_all;

  assign mode  = c0_q[MODE_BIT];
  assign wr_ok = wr_en && ((wr_addr == A_C6) || (wel_q && wp_n));
  assign hit0  = wr_ok && (wr_addr == A_C0);
  assign hit1  = wr_ok && (wr_addr == A_C1);
  assign hit2  = wr_ok && (wr_addr == A_C2);
  assign hit3  = wr_ok && (wr_addr == A_C3);
  assign hit4  = wr_ok && (wr_addr == A_C4);
  assign hit5  = wr_ok && (wr_addr == A_C5);
  assign hit6  = wr_ok && (wr_addr == A_C6);
  assign recall_all = (hit0 || hit5) && !mode;

  always_ff @(posedge clk) begin
    if (hit1 && mode) nv1_q <= wr_data;
    if (hit3 && mode) nv3_q <= wr_data;
    if (hit0) c0_q <= wr_data;
    if (hit2) c2_q <= wr_data;
    if (hit4) c4_q <= wr_data;
    if (hit5) c5_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live1_q <= nv1_q;
      live3_q <= nv3_q;
      wel_q   <= 1'b0;
    end else begin
      if (hit6) wel_q <= wr_data[WEL_BIT];
      if (hit1)                    live1_q <= wr_data;
      else if (hit3 || recall_all) live1_q <= nv1_q;
      if (hit3)                    live3_q <= wr_data;
      else if (hit1 || recall_all) live3_q <= nv3_q;
    end
  end

  assign live1 = live1_q;
  assign live3 = live3_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_C0: rd_data = c0_q;
      A_C1: rd_data = nv1_q;
      A_C2: rd_data = c2_q;
      A_C3: rd_data = nv3_q;
      A_C4: rd_data = c4_q;
      A_C5: rd_data = c5_q;
      A_C6: rd_data[WEL_BIT] = wel_q;
      default: rd_data = '0;
    endcase
  end

  p_nv_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && mode) |=> (nv1_q == $past(wr_data)));
  p_live_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> (live1 == $past(wr_data)));
  p_nv_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit3 && !mode) |=> $stable(nv3_q));
  p_cross_recall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> (live3 == $past(nv3_q)));
  p_bulk_recall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit0 || hit5) && !mode) |=> (live1 == $past(nv1_q) && live3 == $past(nv3_q)));
  p_wp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wp_n && wr_addr != A_C6) |=>
      ($stable(live1) && $stable(live3) && $stable(nv1_q) && $stable(c5_q)));
  p_wel_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wel_q && wr_addr != A_C6) |=> ($stable(c0_q) && $stable(c2_q) && $stable(live1)));
endmodule

// File: tb/shadow_ctl_bank_tb_top.sv
module shadow_ctl_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data, live1, live3;

  always #5 clk = ~clk;

  shadow_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .live1(live1), .live3(live3)
  );

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // kind 0: rd_data at index a, 1: live1, 2: live3
  task automatic expect_val(input int kind, input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = (it.kind == 0) ? rd_data : (it.kind == 1) ? live1 : live3;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (R1..R9 run) actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    expect_val(1, 0, 8'h5A, "R1 live1 after power-up");
    expect_val(2, 0, 8'hC3, "R1 live3 after power-up");
    expect_val(0, 6, 8'h00, "R1 latch clear after power-up");
    expect_val(0, 1, 8'h5A, "R9 read index 1 retained");
    // latch clear: write ignored
    wr(1, 8'h11);
    expect_val(1, 0, 8'h5A, "R8 write without latch ignored");
    wr(6, 8'h02);
    expect_val(0, 6, 8'h02, "R8 latch set by index 6");
    // persist mode 0
    wr(1, 8'h11);
    expect_val(1, 0, 8'h11, "R3 live1 updated");
    expect_val(0, 1, 8'h5A, "R3 retained 1 unchanged");
    wr(3, 8'h22);
    expect_val(2, 0, 8'h22, "R3 live3 updated");
    expect_val(0, 3, 8'hC3, "R3 retained 3 unchanged");
    expect_val(1, 0, 8'h5A, "R4 write 3 recalls live1");
    wr(1, 8'h33);
    expect_val(2, 0, 8'hC3, "R4 write 1 recalls live3");
    wr(3, 8'h44);
    wr(5, 8'h77);
    expect_val(2, 0, 8'hC3, "R5 write 5 recalls live3");
    expect_val(0, 5, 8'h77, "R9 index 5 read back");
    wr(1, 8'h66);
    wr(0, 8'h00);
    expect_val(1, 0, 8'h5A, "R5 write 0 recalls live1");
    wr(1, 8'h66);
    wr(0, 8'h80);
    expect_val(1, 0, 8'h5A, "R6 old mode bit decides recall");
    expect_val(0, 0, 8'h80, "R6 persist bit stored");
    // persist mode 1
    wr(1, 8'hA1);
    expect_val(1, 0, 8'hA1, "R2 live1 written");
    expect_val(0, 1, 8'hA1, "R2 retained 1 written");
    wr(3, 8'hB3);
    expect_val(0, 3, 8'hB3, "R2 retained 3 written");
    expect_val(1, 0, 8'hA1, "R4 recall of live1 from new retained");
    do_reset();
    expect_val(1, 0, 8'hA1, "R2 live1 survives reset");
    expect_val(2, 0, 8'hB3, "R2 live3 survives reset");
    expect_val(0, 6, 8'h00, "R1 latch cleared by reset");
    expect_val(0, 0, 8'h80, "R1 register 0 retained");
    // write protect
    wr(6, 8'h02);
    wr(0, 8'h00);
    wr(1, 8'h11);
    expect_val(1, 0, 8'h11, "R3 unsaved live1");
    expect_val(0, 1, 8'hA1, "R3 read returns retained");
    @(negedge clk); wp_n = 1'b0;
    wr(5, 8'h99);
    expect_val(1, 0, 8'h11, "R7 no recall under protect");
    expect_val(0, 5, 8'h77, "R7 index 5 unchanged under protect");
    wr(6, 8'h00);
    expect_val(0, 6, 8'h00, "R7 latch write allowed under protect");
    @(negedge clk); wp_n = 1'b1;
    wr(2, 8'h12);
    expect_val(0, 2, 8'h00, "R8 index 2 ignored with latch clear");
    wr(6, 8'h02);
    wr(2, 8'h12);
    wr(4, 8'h34);
    expect_val(0, 2, 8'h12, "R9 index 2 read back");
    expect_val(0, 4, 8'h34, "R9 index 4 read back");
    wr(7, 8'hFF);
    expect_val(0, 7, 8'h00, "R9 index 7 reads zero");
    expect_val(1, 0, 8'h11, "R9 index 7 write has no effect");
    do_reset();
    expect_val(1, 0, 8'hA1, "R3 reset restores retained value");
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule